// File: doc/BRIEF.md
# Board Status Controller with LED Blink Sequencer

This block is the small supervisory controller on a plug-in module. It merges the external reset request and the combined supply sense into the active-low FPGA configuration reset. It pulls the shared power-good line low while the local supplies are bad, and releases that line otherwise. It forwards the board-connector JTAG signals to the FPGA. A single status LED reports the module condition as a repeating frame of eight time slots. Each of five prioritised conditions has its own lit/dark pattern.

A free-running divider turns the system clock into slot ticks. `SLOT_CYCLES` clock cycles make one slot, so the default of 3,022,500 cycles at about 24.18 MHz gives a frame of about one second. The status inputs pass through two-stage synchronizers. The condition to display is latched only when a frame ends, so every pattern is shown as a whole frame. The configuration reset, the power-good driver and the JTAG routing are combinational and react at once.

Top module: `board_status_ctrl`

## Requirements
- R1: The displayed condition is picked by fixed priority, highest first: `ext_rst_n` low (reset), `pwr_sense` low (power fail), `pg_pin` low while `pwr_sense` is high (power-good held by carrier), `fpga_done` low (not configured), otherwise ready.
- R2: Within a frame, slot i (slot 0 first) lights `led` (active high) when i is below the lit count of the shown condition: reset 8, power fail 5, carrier-held power-good 4, not configured 1, ready 0.
- R3: `prog_b` is the AND of the raw `ext_rst_n` and `pwr_sense` inputs, with no clock delay.
- R4: `pg_drive_low` is 1, pulling the open-drain line low, exactly while `pwr_sense` is 0. Otherwise it is 0 and the line is left to its pull-up.
- R5: A power-good line read low while `pwr_sense` is high gives the carrier-held pattern, and never the power-fail pattern.
- R6: A slot lasts `SLOT_CYCLES` clocks and a frame lasts 8 slots. The shown condition changes only at a frame boundary, so an input change in mid-frame leaves the rest of that frame unchanged.
- R7: With `jtag_sel` = 0, `fpga_tck`/`fpga_tms`/`fpga_tdi` follow `conn_tck`/`conn_tms`/`conn_tdi`, and `conn_tdo` follows `fpga_tdo`.
- R8: With `jtag_sel` = 1, the FPGA side is parked at `fpga_tck`=0, `fpga_tms`=1, `fpga_tdi`=1, and `conn_tdo` is 1.
- R9: While `por_n` is low, and for the whole first frame after its release, the reset pattern is shown. The first frame starts at the release.
- R10: Status inputs pass two flip-flops before use. A change made less than two clocks before a frame boundary is shown one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| por_n | input | 1 | Power-on reset of the sequencer, active low |
| ext_rst_n | input | 1 | External reset request from connector, active low |
| pwr_sense | input | 1 | Combined supply good sense, active high |
| pg_pin | input | 1 | Level read back from the open-drain power-good line |
| fpga_done | input | 1 | FPGA configuration done |
| jtag_sel | input | 1 | 0 routes JTAG to FPGA, 1 parks the FPGA side |
| conn_tck | input | 1 | Connector JTAG clock |
| conn_tms | input | 1 | Connector JTAG mode select |
| conn_tdi | input | 1 | Connector JTAG data in |
| conn_tdo | output | 1 | Connector JTAG data out |
| fpga_tck | output | 1 | JTAG clock toward FPGA |
| fpga_tms | output | 1 | JTAG mode select toward FPGA |
| fpga_tdi | output | 1 | JTAG data toward FPGA |
| fpga_tdo | input | 1 | JTAG data from FPGA |
| prog_b | output | 1 | FPGA configuration reset, active low |
| pg_drive_low | output | 1 | Enable of the open-drain pull-down on power-good |
| led | output | 1 | Status LED, active high |

## Verification
The sequencer is tried with each condition alone and with several at once, such as reset together with power fail and an unconfigured FPGA, or the carrier hold together with missing done. Each case tells apart the five lit counts and shows that the highest condition wins. Two consecutive frames are compared slot by slot, which separates a stable pattern from one that slips or mixes states. Directed cases change the inputs in mid-frame and just before a boundary. These show whether a frame is ever cut short and whether the synchronizer delay holds a late change back for one frame. The power-good pin is modelled as a wired line, so that the carrier-hold case is distinct from the block's own pull-down.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_PWRFAIL = 3'd1,
    ST_PGHELD  = 3'd2,
    ST_UNCONF  = 3'd3,
    ST_READY   = 3'd4
  } bsc_state_e;

  // Fixed priority: reset > power fail > carrier-held power-good > not done > ready
  function automatic bsc_state_e pick_state(input logic rst_n, input logic pwr,
                                            input logic pg, input logic done);
    if (!rst_n)     return ST_RESET;
    else if (!pwr)  return ST_PWRFAIL;
    else if (!pg)   return ST_PGHELD;
    else if (!done) return ST_UNCONF;
    else            return ST_READY;
  endfunction

  function automatic int unsigned lit_count(input bsc_state_e s);
    case (s)
      ST_RESET:   return 8;
      ST_PWRFAIL: return 5;
      ST_PGHELD:  return 4;
      ST_UNCONF:  return 1;
      default:    return 0;
    endcase
  endfunction

  function automatic logic slot_lit(input bsc_state_e s, input logic [SLOT_W-1:0] slot);
    return (int'(slot) < lit_count(s));
  endfunction
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bsc_divider.sv
module bsc_divider #(
  parameter int CYCLES = 3022500
) (
  input  logic clk,
  input  logic por_n,
  output logic tick
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/bsc_led_seq.sv
module bsc_led_seq
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick,
  input  bsc_state_e        cur_state,
  output logic              led,
  output logic              frame_end,
  output logic [SLOT_W-1:0] slot,
  output bsc_state_e        shown
);
  assign frame_end = tick && (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      slot  <= '0;
      shown <= ST_RESET;
    end else if (tick) begin
      slot <= slot + 1'b1;
      if (frame_end) shown <= cur_state;
    end
  end

  assign led = slot_lit(shown, slot);
endmodule

// File: rtl/board_status_ctrl.sv
module board_status_ctrl
  import bsc_pkg::*;
#(
  parameter int SLOT_CYCLES = 3022500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic pwr_sense,
  input  logic pg_pin,
  input  logic fpga_done,
  input  logic jtag_sel,
  input  logic conn_tck,
  input  logic conn_tms,
  input  logic conn_tdi,
  output logic conn_tdo,
  output logic fpga_tck,
  output logic fpga_tms,
  output logic fpga_tdi,
  input  logic fpga_tdo,
  output logic prog_b,
  output logic pg_drive_low,
  output logic led
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0]  raw_in, sync_in;
  logic              slot_tick;
  logic              frame_end;
  logic [SLOT_W-1:0] slot;
  bsc_state_e        cur_state;
  bsc_state_e        shown;

  // Immediate paths
  assign prog_b       = ext_rst_n & pwr_sense;
  assign pg_drive_low = ~pwr_sense;

  always_comb begin
    if (jtag_sel) begin
      fpga_tck = 1'b0;
      fpga_tms = 1'b1;
      fpga_tdi = 1'b1;
      conn_tdo = 1'b1;
    end else begin
      fpga_tck = conn_tck;
      fpga_tms = conn_tms;
      fpga_tdi = conn_tdi;
      conn_tdo = fpga_tdo;
    end
  end

  // Status path
  assign raw_in = {ext_rst_n, pwr_sense, pg_pin, fpga_done};

  bsc_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .d(raw_in), .q(sync_in)
  );

  assign cur_state = pick_state(sync_in[3], sync_in[2], sync_in[1], sync_in[0]);

  bsc_divider #(.CYCLES(SLOT_CYCLES)) u_div (
    .clk(clk), .por_n(por_n), .tick(slot_tick)
  );

  bsc_led_seq u_seq (
    .clk(clk), .por_n(por_n), .tick(slot_tick), .cur_state(cur_state),
    .led(led), .frame_end(frame_end), .slot(slot), .shown(shown)
  );
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
  import bsc_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              pwr_sense,
  input logic              pg_drive_low,
  input logic              slot_tick,
  input logic              frame_end,
  input logic [SLOT_W-1:0] slot,
  input bsc_state_e        cur_state,
  input bsc_state_e        shown,
  input logic              led
);
  p_shown_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    !frame_end |=> $stable(shown));

  p_latch_prio_r1: assert property (@(posedge clk) disable iff (!por_n)
    frame_end |=> shown == $past(cur_state));

  p_slot_step_r6: assert property (@(posedge clk) disable iff (!por_n)
    slot_tick |=> slot == $past(slot) + 1'b1);

  p_slot_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    !slot_tick |=> $stable(slot));

  p_reset_lit_r2: assert property (@(posedge clk) disable iff (!por_n)
    shown == ST_RESET |-> led);

  p_ready_dark_r2: assert property (@(posedge clk) disable iff (!por_n)
    shown == ST_READY |-> !led);

  p_pg_release_r4: assert property (@(posedge clk) disable iff (!por_n)
    pwr_sense |-> !pg_drive_low);
endmodule

bind board_status_ctrl bsc_checker u_chk (
  .clk(clk), .por_n(por_n), .pwr_sense(pwr_sense), .pg_drive_low(pg_drive_low),
  .slot_tick(slot_tick), .frame_end(frame_end), .slot(slot),
  .cur_state(cur_state), .shown(shown), .led(led)
);

// File: tb/board_status_ctrl_bench.sv
module board_status_ctrl_bench;
  localparam int S = 4;
  localparam int F = 8 * S;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_rst_n = 1'b1, pwr_sense = 1'b1, carrier_hold = 1'b0, fpga_done = 1'b1;
  logic jtag_sel = 1'b0, conn_tck = 1'b0, conn_tms = 1'b0, conn_tdi = 1'b0, fpga_tdo = 1'b0;
  logic pg_pin, conn_tdo, fpga_tck, fpga_tms, fpga_tdi, prog_b, pg_drive_low, led;
  int   edge_cnt = 0;
  int   n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  // Wired open-drain line with pull-up
  assign pg_pin = ~(pg_drive_low | carrier_hold);

  always @(posedge clk) begin
    if (!por_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;
  end

  board_status_ctrl #(.SLOT_CYCLES(S)) u_board_status_ctrl (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pwr_sense(pwr_sense),
    .pg_pin(pg_pin), .fpga_done(fpga_done), .jtag_sel(jtag_sel),
    .conn_tck(conn_tck), .conn_tms(conn_tms), .conn_tdi(conn_tdi), .conn_tdo(conn_tdo),
    .fpga_tck(fpga_tck), .fpga_tms(fpga_tms), .fpga_tdi(fpga_tdi), .fpga_tdo(fpga_tdo),
    .prog_b(prog_b), .pg_drive_low(pg_drive_low), .led(led)
  );

  // {ext_rst_n, pwr_sense, carrier_hold, fpga_done, pattern[7:0] (bit i = slot i), prog_b}
  localparam logic [12:0] VEC [0:8] = '{
    {4'b1101, 8'h00, 1'b1},  // ready
    {4'b1100, 8'h01, 1'b1},  // not configured
    {4'b1111, 8'h0F, 1'b1},  // carrier hold (R5)
    {4'b1110, 8'h0F, 1'b1},  // carrier hold beats not done
    {4'b1001, 8'h1F, 1'b0},  // power fail
    {4'b1010, 8'h1F, 1'b0},  // power fail beats carrier hold and not done
    {4'b0101, 8'hFF, 1'b0},  // reset
    {4'b0010, 8'hFF, 1'b0},  // reset beats everything
    {4'b1101, 8'h00, 1'b1}   // back to ready
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic next_boundary();
    do @(negedge clk); while (edge_cnt % F != 0);
  endtask

  // Entered at a boundary negedge, leaves at the next boundary negedge
  task automatic check_frame(input string req, input logic [7:0] pat);
    for (int j = 0; j < 8; j++) begin
      while (edge_cnt % F != j * S + 1) @(negedge clk);
      check(req, led, pat[j]);
    end
    while (edge_cnt % F != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state, inputs indicate ready
    repeat (3) @(negedge clk);
    check("R9 led in por", led, 1'b1);
    check("R3 prog_b ready inputs", prog_b, 1'b1);
    check("R4 pg released", pg_drive_low, 1'b0);
    por_n = 1'b1;
    check_frame("R9 first frame lit", 8'hFF);
    check_frame("R9 then ready", 8'h00);

    // Table walk: R1 R2 R3 R4 R5
    for (int v = 0; v < 9; v++) begin
      next_boundary();
      {ext_rst_n, pwr_sense, carrier_hold, fpga_done} = VEC[v][12:9];
      #1;
      check("R3 prog_b", prog_b, VEC[v][0]);
      check("R4 pg drive", pg_drive_low, ~pwr_sense);
      next_boundary();
      check_frame("R1 R2 pattern frame 1", VEC[v][8:1]);
      check_frame("R2 pattern frame 2", VEC[v][8:1]);
    end

    // R6: mid-frame change keeps the current (ready) frame intact
    next_boundary();
    while (edge_cnt % F != 3 * S + 1) @(negedge clk);
    ext_rst_n = 1'b0;
    #1 check("R3 prog_b immediate", prog_b, 1'b0);
    for (int j = 3; j < 8; j++) begin
      while (edge_cnt % F != j * S + 1) @(negedge clk);
      check("R6 frame not cut", led, 1'b0);
    end
    while (edge_cnt % F != 0) @(negedge clk);
    check_frame("R6 new state next frame", 8'hFF);

    // R10: change two clocks before boundary is shown one frame late
    ext_rst_n = 1'b1;
    next_boundary();
    check_frame("R10 setup ready", 8'h00);
    while (edge_cnt % F != F - 2) @(negedge clk);
    fpga_done = 1'b0;
    while (edge_cnt % F != 0) @(negedge clk);
    check_frame("R10 late change held", 8'h00);
    check_frame("R10 late change shown", 8'h01);
    fpga_done = 1'b1;

    // R7: passthrough
    jtag_sel = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      {conn_tck, conn_tms, conn_tdi, fpga_tdo} = 4'(k);
      #1;
      check("R7 tck", fpga_tck, conn_tck);
      check("R7 tms", fpga_tms, conn_tms);
      check("R7 tdi", fpga_tdi, conn_tdi);
      check("R7 tdo", conn_tdo, fpga_tdo);
    end

    // R8: parked
    jtag_sel = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      {conn_tck, conn_tms, conn_tdi, fpga_tdo} = 4'(k);
      #1;
      check("R8 tck low", fpga_tck, 1'b0);
      check("R8 tms high", fpga_tms, 1'b1);
      check("R8 tdi high", fpga_tdi, 1'b1);
      check("R8 tdo high", conn_tdo, 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule